// File: doc/BRIEF.md
# Selectable Sigmoid/ReLU Activation Unit

This block sits at the end of one execution lane of a neural network evaluator. It takes one accumulated pre-activation value at a time, in 16-bit signed fixed point with 8 fractional bits. A mode bit that goes with each value picks the output function for the current layer. In rectified-linear mode the output is the input with negative values forced to zero. In sigmoid mode the output is a fifth-order polynomial evaluated by Horner's scheme. One multiply-add is reused for five consecutive steps. The six coefficients come from a Chebyshev fit and are written into the unit through a small register port.

Each result leaves the unit exactly six cycles after its input was accepted, whichever mode was used. Rectified-linear values travel through a delay line of matching length, so results always come out in the order they were accepted. While a sigmoid evaluation holds the shared multiplier, further sigmoid inputs are stalled. Rectified-linear inputs are still accepted in every cycle.

Top module: `act_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 in both modes, and all six coefficients are zero, so any sigmoid input whose magnitude is below 8.0 yields 0.
- R2: With `in_mode` = 0 (rectified linear), the output is the input when the input is non-negative and 0 otherwise, bit for bit in Q8.8.
- R3: With `in_mode` = 1 (sigmoid) and input x (Q8.8 integer code) in the open range −2048 < x < 2048, the accumulator starts at coefficient 5. For k = 4 down to 0 it then becomes floor(acc·x / 256) + coefficient k, with the product and shift taken arithmetically. The output is the final accumulator clamped to the range [0, 256].
- R4: A sigmoid input code of 2048 (8.0) or more gives exactly 256 (1.0), and a code of −2048 or less gives exactly 0, whatever the coefficients are.
- R5: A sigmoid input is accepted only when no evaluation is running. After a sigmoid accept, `in_ready` is 0 for mode 1 during the next five cycles, and a second sigmoid offered at once is accepted exactly 6 cycles after the first.
- R6: Rectified-linear inputs are accepted in every cycle, including while a sigmoid is running. Every result appears on `out_data` with `out_valid` = 1 exactly 6 clock edges after its accepting edge, in acceptance order, and at most one result appears per cycle.
- R7: A cycle with `cfg_we` = 1 and `cfg_sel` in 0..5 writes `cfg_coef` into coefficient number `cfg_sel`, where coefficient 0 is the constant term. The new value is used by sigmoid inputs accepted afterwards. Writes with `cfg_sel` of 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pre-activation value offered |
| in_ready | output | 1 | Unit can take the offered value in its mode |
| in_mode | input | 1 | 0 = rectified linear, 1 = sigmoid |
| in_data | input | 16 | Pre-activation value, signed Q8.8 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient number, 0 = constant term |
| cfg_coef | input | 16 | Coefficient value, signed Q8.8 |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Activated result, signed Q8.8 |

## Verification
The in-line properties assume that coefficient writes happen only while no sigmoid evaluation is running, because the coefficients are read live during each Horner step. The stimulus therefore waits until every expected result has come out before it reprograms the coefficients. The properties also assume that `in_mode` is held steady while `in_valid` waits for `in_ready`, and the driver holds its offer unchanged until the handshake completes. The rectified-linear path is swept over all 65536 input codes. The sigmoid path is swept over the fitted range with three coefficient sets, plus the saturation boundaries.

// File: rtl/act_pkg.sv
package act_pkg;

    typedef enum logic {
        ACT_RELU = 1'b0,
        ACT_SIGM = 1'b1
    } act_mode_e;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_FRAC_W = 8;
    localparam int unsigned DEF_ACC_W  = 32;
    localparam int unsigned DEF_ORDER  = 5;
    localparam int unsigned DEF_SAT    = 8;

endpackage

// File: rtl/act_horner.sv
module act_horner #(
    parameter int unsigned DW      = 16,
    parameter int unsigned FW      = 8,
    parameter int unsigned AW      = 32,
    parameter int unsigned ORDER   = 5,
    parameter int unsigned SAT_INT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] coef [ORDER+1],
    output logic                 busy,
    output logic                 done,
    output logic        [DW-1:0] result
);
    localparam int unsigned CW = $clog2(ORDER + 1);
    localparam int unsigned PW = AW + DW;
    localparam logic signed [DW-1:0] XLIM  = DW'(SAT_INT * (2 ** FW));
    localparam logic signed [DW-1:0] XNEG  = -XLIM;
    localparam logic signed [DW-1:0] ONE   = DW'(2 ** FW);
    localparam logic signed [AW-1:0] ONE_A = AW'(ONE);

    typedef struct packed {
        logic [CW-1:0]        cnt;
        logic signed [DW-1:0] x;
        logic signed [AW-1:0] acc;
        logic                 hi;
        logic                 lo;
        logic                 done;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [CW-1:0]        idx;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] step;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        idx        = eng_q.cnt - CW'(1);
        prod       = PW'($signed(eng_q.acc)) * PW'($signed(eng_q.x));
        step       = AW'(prod >>> FW) + AW'(coef[idx]);
        if (start) begin
            eng_d.x   = x_in;
            eng_d.acc = AW'(coef[ORDER]);
            eng_d.cnt = CW'(ORDER);
            eng_d.hi  = (x_in >= XLIM);
            eng_d.lo  = (x_in <= XNEG);
        end else if (eng_q.cnt != '0) begin
            eng_d.acc  = step;
            eng_d.cnt  = eng_q.cnt - CW'(1);
            eng_d.done = (eng_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        if (eng_q.hi)                       result = ONE;
        else if (eng_q.lo)                  result = '0;
        else if ($signed(eng_q.acc) < 0)     result = '0;
        else if ($signed(eng_q.acc) > ONE_A) result = ONE;
        else                                 result = DW'(eng_q.acc);
    end

    assign busy = (eng_q.cnt != '0);
    assign done = eng_q.done;

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (eng_q.cnt == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.done |=> !eng_q.done);

endmodule

// File: rtl/act_relu_pipe.sv
module act_relu_pipe #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d
);
    typedef struct packed {
        logic [DEPTH-1:0]         v;
        logic [DEPTH-1:0][DW-1:0] d;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic [DW-1:0] rect;

    always_comb begin
        rect   = in_d[DW-1] ? '0 : in_d;
        pipe_d = pipe_q;
        pipe_d.v    = {pipe_q.v[DEPTH-2:0], in_v};
        pipe_d.d    = {pipe_q.d[DEPTH-2:0], rect};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_v = pipe_q.v[DEPTH-1];
    assign out_d = pipe_q.d[DEPTH-1];

    // R2
    relu_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> !out_d[DW-1]);

endmodule

// File: rtl/act_unit.sv
module act_unit
    import act_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned FRAC_W  = DEF_FRAC_W,
    parameter int unsigned ACC_W   = DEF_ACC_W,
    parameter int unsigned ORDER   = DEF_ORDER,
    parameter int unsigned SAT_INT = DEF_SAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_coef,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned LAT = ORDER + 1;
    localparam logic signed [DATA_W-1:0] ONE = DATA_W'(2 ** FRAC_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    logic signed [DATA_W-1:0] coef_q [ORDER+1];
    logic signed [DATA_W-1:0] coef_d [ORDER+1];
    logic              sig_busy, sig_done, sig_start, relu_in;
    logic              relu_v, accept;
    logic [DATA_W-1:0] relu_d, sig_res;
    out_t              out_d_s, out_q_s;

    for (genvar g = 0; g <= ORDER; g++) begin : g_coef
        always_comb begin
            coef_d[g] = coef_q[g];
            if (cfg_we && (cfg_sel == 3'(g))) coef_d[g] = cfg_coef;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) coef_q[g] <= '0;
            else        coef_q[g] <= coef_d[g];
        end
    end

    assign in_ready  = (in_mode == ACT_RELU) || !sig_busy;
    assign accept    = in_valid && in_ready;
    assign sig_start = accept && (in_mode == ACT_SIGM);
    assign relu_in   = accept && (in_mode == ACT_RELU);

    act_horner #(
        .DW(DATA_W), .FW(FRAC_W), .AW(ACC_W), .ORDER(ORDER), .SAT_INT(SAT_INT)
    ) i_horner (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sig_start),
        .x_in  ($signed(in_data)),
        .coef  (coef_q),
        .busy  (sig_busy),
        .done  (sig_done),
        .result(sig_res)
    );

    act_relu_pipe #(.DW(DATA_W), .DEPTH(LAT)) i_relu (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (relu_in),
        .in_d (in_data),
        .out_v(relu_v),
        .out_d(relu_d)
    );

    always_comb begin
        out_d_s.valid = relu_v || sig_done;
        out_d_s.data  = relu_v ? relu_d : sig_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q_s <= '0;
        else        out_q_s <= out_d_s;
    end

    assign out_valid = out_q_s.valid;
    assign out_data  = out_q_s.data;

    // R6
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({relu_v, sig_done}));

    // R3
    sig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_done |=> (out_valid && ($signed(out_data) >= 0) && ($signed(out_data) <= ONE)));

endmodule

// File: tb/test_act_unit.sv
`timescale 1ns/1ps
module test_act_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_mode = 1'b0;
    logic [15:0] in_data = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_coef = '0;
    logic        out_valid;
    logic [15:0] out_data;

    always #2 clk = ~clk;

    act_unit i_act_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_data(in_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_coef(cfg_coef), .out_valid(out_valid), .out_data(out_data)
    );

    int     cyc = 0;
    int     n_chk = 0;
    int     n_err = 0;
    int     q_dat[$];
    int     q_cyc[$];
    string  q_req[$];
    longint bc[6];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_sig(input int x);
        longint acc;
        if (x >= 2048)  return 256;
        if (x <= -2048) return 0;
        acc = bc[5];
        for (int k = 4; k >= 0; k--) acc = ((acc * x) >>> 8) + bc[k];
        if (acc < 0)   return 0;
        if (acc > 256) return 256;
        return int'(acc);
    endfunction

    function automatic int model_relu(input int x);
        return (x < 0) ? 0 : x;
    endfunction

    always @(negedge clk) begin : mon
        int e;
        int ec;
        string r;
        if (rst_n && out_valid) begin
            if (q_dat.size() == 0) begin
                chk(1'b0, "R6 unexpected result", int'($signed(out_data)), -1);
            end else begin
                e  = q_dat.pop_front();
                ec = q_cyc.pop_front();
                r  = q_req.pop_front();
                chk(int'($signed(out_data)) == e, r, int'($signed(out_data)), e);
                chk(cyc == ec, "R6 latency", cyc, ec);
            end
        end
    end

    task automatic send(input int x, input bit m, input int e, input string r, output int ac);
        in_valid = 1'b1;
        in_data  = 16'(x);
        in_mode  = m;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        ac = cyc + 1;
        q_dat.push_back(e);
        q_cyc.push_back(cyc + 7);
        q_req.push_back(r);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wcoef(input int sel, input int val);
        cfg_we   = 1'b1;
        cfg_sel  = 3'(sel);
        cfg_coef = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 6) bc[sel] = longint'(16'(val) ^ 16'h8000) - 32768;
    endtask

    task automatic drain();
        while (q_dat.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_set(input int c0, input int c1, input int c2,
                            input int c3, input int c4, input int c5);
        wcoef(0, c0); wcoef(1, c1); wcoef(2, c2);
        wcoef(3, c3); wcoef(4, c4); wcoef(5, c5);
    endtask

    task automatic sig_sweep(input int step, input string r);
        int ac;
        for (int x = -2300; x <= 2300; x += step) send(x, 1'b1, model_sig(x), r, ac);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin : main
        int a1;
        int a2;
        int b;
        for (int k = 0; k < 6; k++) bc[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        in_mode = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready sigmoid after reset", int'(in_ready), 1);
        in_mode = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1 in_ready relu after reset", int'(in_ready), 1);
        @(negedge clk);
        send(300, 1'b1, 0, "R1 zero coefficients", a1);
        send(-700, 1'b1, 0, "R1 zero coefficients", a1);
        drain();

        // R2: every input code through rectified linear, back to back
        for (int x = -32768; x < 32768; x++) send(x, 1'b0, model_relu(x), "R2", a1);
        drain();

        // R3: sigmoid-like fit
        load_set(128, 56, 0, -1, 0, 0);
        sig_sweep(7, "R3 set A");
        drain();
        // R3: every coefficient nonzero, Horner order matters
        load_set(128, 60, 3, -2, 1, -1);
        sig_sweep(5, "R3 set B");
        drain();

        // R4: saturation boundaries with extreme coefficients
        load_set(-500, 32767, -32768, 20000, -20000, 32767);
        send(2047, 1'b1, model_sig(2047), "R3 edge", a1);
        send(-2047, 1'b1, model_sig(-2047), "R3 edge", a1);
        send(2048, 1'b1, 256, "R4 high", a1);
        send(-2048, 1'b1, 0, "R4 low", a1);
        send(32767, 1'b1, 256, "R4 high", a1);
        send(-32768, 1'b1, 0, "R4 low", a1);
        send(5000, 1'b1, 256, "R4 high", a1);
        sig_sweep(97, "R3 set C");
        drain();

        // R7: writes to unused numbers change nothing; real writes take effect
        load_set(128, 60, 3, -2, 1, -1);
        wcoef(6, 12345);
        wcoef(7, -4321);
        send(700, 1'b1, model_sig(700), "R7 ignored select", a1);
        send(-900, 1'b1, model_sig(-900), "R7 ignored select", a1);
        send(0, 1'b1, 128, "R7 ignored select", a1);
        drain();
        wcoef(0, 40);
        send(0, 1'b1, 40, "R7 constant term written", a1);
        send(512, 1'b1, model_sig(512), "R7 written", a1);
        drain();

        // R5: back-to-back sigmoid stalls
        send(100, 1'b1, model_sig(100), "R5 first", a1);
        in_mode = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R5 ready low while busy", int'(in_ready), 0);
        in_mode = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R6 relu ready while busy", int'(in_ready), 1);
        @(negedge clk);
        drain();
        send(-150, 1'b1, model_sig(-150), "R5 first", a1);
        send(250, 1'b1, model_sig(250), "R5 second", a2);
        chk(a2 - a1 == 6, "R5 accept spacing", a2 - a1, 6);
        drain();

        // R6: relu stream interleaved with a running sigmoid
        send(-300, 1'b1, model_sig(-300), "R6 sigmoid", a1);
        for (int k = 1; k <= 5; k++) begin
            send(k * 37 - 90, 1'b0, model_relu(k * 37 - 90), "R6 relu in order", b);
            chk(b - a1 == k, "R6 relu accepted while busy", b - a1, k);
        end
        send(333, 1'b1, model_sig(333), "R6 sigmoid", a2);
        chk(a2 - a1 == 6, "R5 spacing with relu", a2 - a1, 6);
        send(-5, 1'b0, 0, "R6 relu after sigmoid", b);
        drain();

        summary();
        $finish;
    end
endmodule